// File: doc/BRIEF.md
# Host Link Frame Codec with Sleep Command and Power Telemetry

This block sits between a byte-wide serial link and the power-management logic of a chip. Its receive half watches the incoming byte stream for framed commands and checks each frame. It gives a one-cycle sleep request when a correct sleep command arrives. All other commands are parsed and checked, but they do nothing here.

A frame has six parts in this order: a start byte 0x02, a length byte, a command byte, the payload, a CRC-16 and an end byte 0x03. The length byte counts the command byte together with the payload. The CRC covers the command byte and the payload. It uses polynomial 0x1021 with initial value 0x0000 and no reflection, and it is sent high byte first.

The transmit half sends a 17-byte power report, command 0x81, when it sees a request pulse. The report is taken from the state and estimate inputs in the cycle the request is accepted. It leaves the block one byte at a time on a valid/ready handshake.

Top module: `hostlink_framer`

## Requirements
- R1: A frame of bytes 02 01 09, then the correct CRC high byte and low byte, then 03, gives `sleep_req` high for exactly one cycle. The pulse appears in the cycle after the end byte is taken.
- R2: The CRC is CRC-16 with polynomial 0x1021, initial value 0 and no reflection, taken over the command and payload bytes and compared high byte first. A frame whose received CRC differs gives no pulse.
- R3: While the receiver is waiting for a frame, every byte other than 0x02 is discarded and starts nothing.
- R4: A length byte of 0 drops the frame. The next byte is treated as a possible start byte.
- R5: A length byte greater than `MAX_LEN` (default 64) drops the frame in the same way.
- R6: If the byte in the end position is not 0x03, the frame is dropped and that byte is not reused as a start byte. A later correct frame is still accepted.
- R7: A frame that is correct but has a command other than 0x09, or that has command 0x09 with any payload (length above 1), gives no pulse.
- R8: A `tlm_req` pulse while the transmitter is idle sends 17 bytes in this order: 02, 0C, 81, then the 11-byte little-endian record, then the CRC high byte, the CRC low byte and 03. The record is state (1 byte), total mA (2), audio mA (2), display mA (2), idle ms (4). The field values are the ones present in the request cycle.
- R9: `tx_data` advances only on a cycle where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, the byte on `tx_data` and `tx_valid` stay as they are.
- R10: `tlm_req` and any field changes are ignored from the first byte until the end byte has been taken, including the cycle in which the end byte is taken. After that, `tx_valid` falls.
- R11: After reset, `sleep_req` and `tx_valid` are low and the receiver is waiting for a start byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 8 | Incoming byte |
| rx_valid | input | 1 | Incoming byte present this cycle |
| sleep_req | output | 1 | One-cycle pulse for an accepted sleep command |
| tlm_req | input | 1 | Request to send a power report |
| pwr_state | input | 8 | Power state code for the report |
| cur_total_ma | input | 16 | Total current estimate, mA |
| cur_audio_ma | input | 16 | Audio subsystem current estimate, mA |
| cur_disp_ma | input | 16 | Display subsystem current estimate, mA |
| idle_time_ms | input | 32 | Time since last activity, ms |
| tx_data | output | 8 | Outgoing byte |
| tx_valid | output | 1 | Outgoing byte present |
| tx_ready | input | 1 | Sink takes the outgoing byte this cycle |

## Verification
The hardest case to reach from the ports is a request that arrives in the very cycle the end byte is taken. At that moment the sender is about to go idle, so a design that frees itself one cycle early would start a second frame. The stimulus reaches this case on purpose. It keeps ready high through the last byte and pulses the request in that same cycle. It then checks that `tx_valid` stays low for the following cycles. Random ready stalls and mid-frame field changes test the capture and hold rules. On the receive side, corrupted CRCs, payload-carrying sleep frames, bad lengths and misplaced end bytes are mixed with correct frames. Filler bytes that contain no 0x02 are placed between frames.

// File: rtl/hlf_pkg.sv
package hlf_pkg;
  localparam int BYTE_W = 8;
  localparam int CRC_W = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
  localparam logic [BYTE_W-1:0] SOF = 8'h02;
  localparam logic [BYTE_W-1:0] EOF = 8'h03;
  localparam logic [BYTE_W-1:0] CMD_SLEEP = 8'h09;
  localparam logic [BYTE_W-1:0] CMD_POWER = 8'h81;
  localparam int PWR_PAYLOAD = 11;
  localparam int PWR_FRAME = PWR_PAYLOAD + 6;
  localparam int PWR_LEN = PWR_PAYLOAD + 1;
  // byte positions inside the power frame
  localparam int POS_PAY0 = 3;
  localparam int POS_PAYN = POS_PAY0 + PWR_PAYLOAD - 1;
  localparam int POS_CRCH = POS_PAYN + 1;
  localparam int POS_CRCL = POS_PAYN + 2;
  localparam int POS_END = PWR_FRAME - 1;

  typedef enum logic [2:0] {
    RX_HUNT, RX_LEN, RX_CMD, RX_BODY, RX_CRC_HI, RX_CRC_LO, RX_END
  } rx_state_e;
endpackage

// File: rtl/hlf_crc_step.sv
module hlf_crc_step
  import hlf_pkg::*;
#(
  parameter int W = CRC_W,
  parameter logic [W-1:0] POLY = CRC_POLY
) (
  input  logic [W-1:0]      crc_in,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [W-1:0]      crc_out
);
  logic [W-1:0] acc;
  always_comb begin
    acc = crc_in ^ {byte_in, {(W-BYTE_W){1'b0}}};
    for (int b = 0; b < BYTE_W; b++) begin
      if (acc[W-1]) acc = (acc << 1) ^ POLY;
      else          acc = acc << 1;
    end
    crc_out = acc;
  end
endmodule

// File: rtl/hlf_rx.sv
module hlf_rx
  import hlf_pkg::*;
#(
  parameter int MAX_LEN = 64,
  localparam int CNT_W = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_valid,
  output logic              sleep_req
);
  rx_state_e          state;
  logic [CNT_W-1:0]   len_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [BYTE_W-1:0]  cmd_q;
  logic [CRC_W-1:0]   crc_q;
  logic [BYTE_W-1:0]  crc_hi_q;
  logic               crc_ok_q;
  logic [CRC_W-1:0]   crc_seed;
  logic [CRC_W-1:0]   crc_nxt;

  assign crc_seed = (state == RX_CMD) ? '0 : crc_q;

  hlf_crc_step u_crc (
    .crc_in (crc_seed),
    .byte_in(rx_data),
    .crc_out(crc_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RX_HUNT;
      len_q     <= '0;
      cnt_q     <= '0;
      cmd_q     <= '0;
      crc_q     <= '0;
      crc_hi_q  <= '0;
      crc_ok_q  <= 1'b0;
      sleep_req <= 1'b0;
    end else begin
      sleep_req <= 1'b0;
      if (rx_valid) begin
        unique case (state)
          RX_HUNT: if (rx_data == SOF) state <= RX_LEN;
          RX_LEN: begin
            if (rx_data == '0 || 32'(rx_data) > MAX_LEN) begin
              state <= RX_HUNT;
            end else begin
              len_q <= CNT_W'(rx_data);
              state <= RX_CMD;
            end
          end
          RX_CMD: begin
            cmd_q <= rx_data;
            crc_q <= crc_nxt;
            cnt_q <= CNT_W'(1);
            state <= (len_q == CNT_W'(1)) ? RX_CRC_HI : RX_BODY;
          end
          RX_BODY: begin
            crc_q <= crc_nxt;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q + 1'b1 == len_q) state <= RX_CRC_HI;
          end
          RX_CRC_HI: begin
            crc_hi_q <= rx_data;
            state    <= RX_CRC_LO;
          end
          RX_CRC_LO: begin
            crc_ok_q <= ({crc_hi_q, rx_data} == crc_q);
            state    <= RX_END;
          end
          RX_END: begin
            sleep_req <= (rx_data == EOF) && crc_ok_q &&
                         (cmd_q == CMD_SLEEP) && (len_q == CNT_W'(1));
            state     <= RX_HUNT;
          end
          default: state <= RX_HUNT;
        endcase
      end
    end
  end

  // R1: the sleep pulse lasts one cycle
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst)
    sleep_req |=> !sleep_req);
  // R3: non-start bytes keep the parser waiting
  a_r3_hunt_holds: assert property (@(posedge clk) disable iff (rst)
    (state == RX_HUNT && rx_valid && rx_data != SOF) |=> state == RX_HUNT);
  // R4: zero length returns to waiting
  a_r4_zero_len: assert property (@(posedge clk) disable iff (rst)
    (state == RX_LEN && rx_valid && rx_data == '0) |=> state == RX_HUNT);
  // R6: a pulse only follows a taken end-position byte
  a_r6_pulse_after_end: assert property (@(posedge clk) disable iff (rst)
    sleep_req |-> ($past(state) == RX_END && $past(rx_valid)));
endmodule

// File: rtl/hlf_tx.sv
module hlf_tx
  import hlf_pkg::*;
#(
  parameter int ST_W = 8,
  parameter int MA_W = 16,
  parameter int IDLE_W = 32,
  localparam int REC_W = ST_W + 3 * MA_W + IDLE_W,
  localparam int IDX_W = $clog2(PWR_FRAME)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tlm_req,
  input  logic [ST_W-1:0]   pwr_state,
  input  logic [MA_W-1:0]   cur_total_ma,
  input  logic [MA_W-1:0]   cur_audio_ma,
  input  logic [MA_W-1:0]   cur_disp_ma,
  input  logic [IDLE_W-1:0] idle_time_ms,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_valid,
  input  logic              tx_ready
);
  logic [REC_W-1:0]  rec_q;
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  idx_nxt;
  logic [CRC_W-1:0]  crc_q;
  logic [CRC_W-1:0]  crc_step;
  logic [CRC_W-1:0]  crc_nxt;
  logic [BYTE_W-1:0] byte_nxt;
  logic [IDX_W-1:0]  pay_k;
  logic              take;
  logic              last;

  assign take    = tx_valid && tx_ready;
  assign last    = (idx_q == IDX_W'(POS_END));
  assign idx_nxt = idx_q + 1'b1;
  assign pay_k   = idx_nxt - IDX_W'(POS_PAY0);

  hlf_crc_step u_crc (
    .crc_in (crc_q),
    .byte_in(tx_data),
    .crc_out(crc_step)
  );

  always_comb begin
    crc_nxt = (idx_q >= IDX_W'(2) && idx_q <= IDX_W'(POS_PAYN)) ? crc_step : crc_q;
    byte_nxt = EOF;
    if (idx_nxt == IDX_W'(1))             byte_nxt = BYTE_W'(PWR_LEN);
    else if (idx_nxt == IDX_W'(2))        byte_nxt = CMD_POWER;
    else if (idx_nxt <= IDX_W'(POS_PAYN)) byte_nxt = rec_q[BYTE_W*pay_k +: BYTE_W];
    else if (idx_nxt == IDX_W'(POS_CRCH)) byte_nxt = crc_nxt[CRC_W-1 -: BYTE_W];
    else if (idx_nxt == IDX_W'(POS_CRCL)) byte_nxt = crc_nxt[BYTE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
      idx_q    <= '0;
      crc_q    <= '0;
      rec_q    <= '0;
    end else if (!tx_valid) begin
      if (tlm_req) begin
        tx_valid <= 1'b1;
        tx_data  <= SOF;
        idx_q    <= '0;
        crc_q    <= '0;
        rec_q    <= {idle_time_ms, cur_disp_ma, cur_audio_ma, cur_total_ma, pwr_state};
      end
    end else if (take) begin
      if (last) begin
        tx_valid <= 1'b0;
      end else begin
        idx_q   <= idx_nxt;
        tx_data <= byte_nxt;
        crc_q   <= crc_nxt;
      end
    end
  end

  // R8: every frame opens with the start byte
  a_r8_first_sof: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_valid) |-> tx_data == SOF);
  // R9: a stalled byte is held
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  // R10: end byte taken means idle next cycle, whatever the request
  a_r10_end_idle: assert property (@(posedge clk) disable iff (rst)
    (take && last) |=> !tx_valid);
  // R10: the snapshot stays fixed while busy
  a_r10_rec_frozen: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && $past(tx_valid)) |-> $stable(rec_q));
endmodule

// File: rtl/hostlink_framer.sv
module hostlink_framer
  import hlf_pkg::*;
#(
  parameter int MAX_LEN = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  rx_data,
  input  logic        rx_valid,
  output logic        sleep_req,
  input  logic        tlm_req,
  input  logic [7:0]  pwr_state,
  input  logic [15:0] cur_total_ma,
  input  logic [15:0] cur_audio_ma,
  input  logic [15:0] cur_disp_ma,
  input  logic [31:0] idle_time_ms,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  input  logic        tx_ready
);
  hlf_rx #(.MAX_LEN(MAX_LEN)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .rx_data  (rx_data),
    .rx_valid (rx_valid),
    .sleep_req(sleep_req)
  );

  hlf_tx u_tx (
    .clk         (clk),
    .rst         (rst),
    .tlm_req     (tlm_req),
    .pwr_state   (pwr_state),
    .cur_total_ma(cur_total_ma),
    .cur_audio_ma(cur_audio_ma),
    .cur_disp_ma (cur_disp_ma),
    .idle_time_ms(idle_time_ms),
    .tx_data     (tx_data),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready)
  );
endmodule

// File: tb/hostlink_framer_bench.sv
`timescale 1ns/1ps
module hostlink_framer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0;
  logic        sleep_req;
  logic        tlm_req = 1'b0;
  logic [7:0]  pwr_state = '0;
  logic [15:0] cur_total_ma = '0, cur_audio_ma = '0, cur_disp_ma = '0;
  logic [31:0] idle_time_ms = '0;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b0;

  int n_chk = 0, n_bad = 0, pulses = 0;
  bit done = 0;

  always #2 clk = ~clk;

  hostlink_framer u_hostlink_framer (
    .clk(clk), .rst(rst), .rx_data(rx_data), .rx_valid(rx_valid),
    .sleep_req(sleep_req), .tlm_req(tlm_req), .pwr_state(pwr_state),
    .cur_total_ma(cur_total_ma), .cur_audio_ma(cur_audio_ma),
    .cur_disp_ma(cur_disp_ma), .idle_time_ms(idle_time_ms),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready)
  );

  always @(negedge clk) if (!rst && sleep_req) pulses++;

  function automatic logic [15:0] crc16(input logic [7:0] b[$]);
    logic [15:0] c = 16'h0000;
    foreach (b[i]) begin
      c ^= {b[i], 8'h00};
      for (int k = 0; k < 8; k++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
    end
    return c;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_data = b;
    rx_valid = 1'b1;
    @(posedge clk);
  endtask

  task automatic rx_gap();
    @(negedge clk);
    rx_valid = 1'b0;
    @(negedge clk);
  endtask

  // corrupt: flip the CRC low byte; bad_end: replace end byte by 0x02
  task automatic send_frame(input logic [7:0] cmd, input int plen, input bit corrupt,
                            input bit bad_end);
    logic [7:0] body[$];
    logic [15:0] c;
    body.push_back(cmd);
    for (int i = 0; i < plen; i++) body.push_back(8'($urandom));
    c = crc16(body);
    if (corrupt) c[7:0] = ~c[7:0];
    send_byte(8'h02);
    send_byte(8'(body.size()));
    foreach (body[i]) send_byte(body[i]);
    send_byte(c[15:8]);
    send_byte(c[7:0]);
    send_byte(bad_end ? 8'h02 : 8'h03);
  endtask

  task automatic send_filler(input int n);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b = 8'($urandom);
      if (b == 8'h02) b = 8'h55;
      send_byte(b);
    end
  endtask

  task automatic rx_expect(input string req, input int exp_pulses);
    rx_gap();
    check(req, pulses, exp_pulses);
  endtask

  // one telemetry frame with random stalls and ignored requests
  task automatic run_tlm(input int stall_pct);
    logic [7:0] exp[$];
    logic [7:0] body[$];
    logic [15:0] c;
    logic [7:0] got;
    int n = 0;
    logic [7:0] prev_d = '0;
    bit prev_stall = 0;
    @(negedge clk);
    pwr_state = 8'($urandom); cur_total_ma = 16'($urandom);
    cur_audio_ma = 16'($urandom); cur_disp_ma = 16'($urandom);
    idle_time_ms = $urandom;
    body = {8'h81, pwr_state, cur_total_ma[7:0], cur_total_ma[15:8],
            cur_audio_ma[7:0], cur_audio_ma[15:8], cur_disp_ma[7:0], cur_disp_ma[15:8],
            idle_time_ms[7:0], idle_time_ms[15:8], idle_time_ms[23:16], idle_time_ms[31:24]};
    c = crc16(body);
    exp = {8'h02, 8'h0C};
    foreach (body[i]) exp.push_back(body[i]);
    exp.push_back(c[15:8]); exp.push_back(c[7:0]); exp.push_back(8'h03);
    tlm_req = 1'b1;
    while (n < 17) begin
      @(negedge clk);
      tlm_req = 1'b0;
      if (prev_stall) check("R9 held byte", {tx_valid, tx_data}, {1'b1, prev_d});
      tx_ready = ($urandom % 100) >= stall_pct;
      if (n == 16) tx_ready = 1'b1;
      if ($urandom % 4 == 0 || n == 16) begin
        // R10: change fields and request while busy
        tlm_req = 1'b1;
        pwr_state = 8'($urandom); idle_time_ms = $urandom;
      end
      if (!tx_valid) begin
        check("R8 valid during frame", tx_valid, 1'b1);
        n = 17;
      end else begin
        prev_stall = !tx_ready;
        prev_d = tx_data;
        if (tx_ready) begin
          got = tx_data;
          check($sformatf("R8 byte %0d", n), got, exp[n]);
          n++;
        end
      end
    end
    @(negedge clk);
    tlm_req = 1'b0;
    tx_ready = 1'b0;
    for (int i = 0; i < 4; i++) begin
      check("R10 idle after end byte", tx_valid, 1'b0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int exp_p = 0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R11 sleep_req after reset", sleep_req, 1'b0);
    check("R11 tx_valid after reset", tx_valid, 1'b0);

    // R1 plain sleep frame
    send_frame(8'h09, 0, 0, 0); exp_p++; rx_expect("R1 sleep pulse", exp_p);
    // R2 bad CRC
    send_frame(8'h09, 0, 1, 0); rx_expect("R2 bad crc no pulse", exp_p);
    // R3 filler then frame
    send_filler(20);
    rx_expect("R3 filler no pulse", exp_p);
    send_frame(8'h09, 0, 0, 0); exp_p++; rx_expect("R3 frame after filler", exp_p);
    // R4 zero length, next byte starts a frame
    send_byte(8'h02); send_byte(8'h00);
    send_frame(8'h09, 0, 0, 0); exp_p++; rx_expect("R4 zero length then frame", exp_p);
    // R5 over-long length
    send_byte(8'h02); send_byte(8'd65);
    send_frame(8'h09, 0, 0, 0); exp_p++; rx_expect("R5 long length then frame", exp_p);
    // R6 wrong end byte (0x02) is not reused
    send_frame(8'h09, 0, 0, 1);
    send_byte(8'h01); send_byte(8'h09);
    rx_expect("R6 missing end no pulse", exp_p);
    send_frame(8'h09, 0, 0, 0); exp_p++; rx_expect("R6 recovery frame", exp_p);
    // R7 other command, sleep with payload
    send_frame(8'h81, 11, 0, 0); rx_expect("R7 other command", exp_p);
    send_frame(8'h09, 2, 0, 0); rx_expect("R7 sleep with payload", exp_p);

    // random receive mix
    for (int i = 0; i < 60; i++) begin
      int kind = $urandom % 4;
      logic [7:0] cmd = (kind == 0) ? 8'h09 : 8'($urandom);
      int plen = (kind == 0) ? 0 : $urandom % 6;
      bit bad = (kind == 1);
      if (cmd == 8'h09 && plen == 0 && !bad) exp_p++;
      send_frame(cmd, plen, bad, 0);
      send_filler($urandom % 4);
      rx_expect("R1 R2 R7 random frame", exp_p);
    end

    // transmit
    run_tlm(0);
    run_tlm(50);
    for (int i = 0; i < 8; i++) run_tlm(30);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule